// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Clear-to-Send Gating

This block sends 8-bit words over a clocked serial link and generates the serial clock itself. A host writes a byte into a one-entry holding buffer. When the link is free, the byte moves into a shift register. The block then drives the serial clock and the data line, least significant bit first. Data changes on the falling edge of the clock, so the receiver samples on the rising edge. The clock idles high.

The bit timing comes from two stages. A prescaler selects one of four count sources: the system clock divided by 1, 2, 8 or 32. A reload divider then counts that source. Each clock phase lasts n+1 source pulses, so a full serial clock period is 2(n+1) source periods.

A new word may start only at a word boundary, and only when three conditions hold:
- the transmit enable is high;
- the active-low clear-to-send input reads low after a two-flop synchronizer;
- the buffer holds a word.

A word already shifting always runs to the end. If a word is waiting when the current one finishes, it follows back-to-back with no idle clock phase. One interrupt request line is provided. A select input decides whether it sets on a buffer hand-over or on transmission complete. An acknowledge input clears it.

The controller has three states: IDLE, LOW and HIGH.
- IDLE: clock high, data line high. START moves to LOW when a word may begin.
- LOW: clock low. RISE moves to HIGH on a divider tick.
- HIGH: clock high. On a divider tick, one of three transitions is taken:
  - NEXT_BIT moves back to LOW when bits remain.
  - CHAIN moves to LOW with the next word loaded when the last bit is done and a start is allowed.
  - FINISH moves to IDLE when the last bit is done and no start is allowed.

Top module: `csio_tx`

## Requirements
- R1: After reset, `sclk` = 1, `sdata` = 1, `buf_empty` = 1, `shift_empty` = 1 and `irq` = 0.
- R2: Each low and each high phase of `sclk` lasts (n+1)·P system clocks. Here n is `div_n` and P is 1, 2, 8 or 32 for `clk_sel` = 0, 1, 2, 3 respectively.
- R3: A word is sent as 8 bits, bit 0 first. `sdata` changes only together with a falling edge of `sclk`, and each bit is valid at the rising edge.
- R4: A write (`wr_en` high for one cycle) makes `buf_empty` read 0 in the next cycle. `buf_empty` returns to 1 in the cycle the word enters the shift register, and that cycle starts a low phase of `sclk`.
- R5: `shift_empty` is 0 from the first low phase of a word until its last high phase ends. It then reads 1 with `sclk` high when no word follows.
- R6: While the synchronized `cts_n` is high, no word starts and `sclk` does not pulse. A word already shifting completes even if `cts_n` rises part-way through it.
- R7: While `tx_en` is low, no word starts and `sclk` does not pulse.
- R8: A word waiting in the buffer when the previous one ends is chained without extra idle time. The high phase between the two words lasts exactly the R2 phase length, and `shift_empty` stays 0.
- R9: With `irq_sel` = 0, `irq` sets in the cycle a word moves from the buffer into the shift register.
- R10: With `irq_sel` = 1, `irq` sets only when a word ends with no word following. With either setting, `irq_ack` clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; gates word starts |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| clk_sel | input | 2 | Count-source select: 0 → /1, 1 → /2, 2 → /8, 3 → /32 |
| div_n | input | 8 | Divider reload value n |
| irq_sel | input | 1 | 0: interrupt on buffer hand-over, 1: on transmission complete |
| irq_ack | input | 1 | Clears the interrupt request |
| wr_en | input | 1 | One-cycle write strobe for the transmit buffer |
| wr_data | input | 8 | Byte to transmit |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, LSB first |
| buf_empty | output | 1 | Transmit buffer empty flag |
| shift_empty | output | 1 | Shift register empty flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends isolated single words under each of the four count-source selections with different reload values. This separates prescaler errors from divider errors through the measured phase lengths, and checks bit order through the scoreboard. Words written while another is still shifting show whether chaining skips or stretches the boundary high phase. Holding `cts_n` high or `tx_en` low before a write shows that nothing starts. Raising `cts_n` in the middle of a word with a second word pending shows that the current word completes while the pending one waits. Runs with each `irq_sel` setting tell the hand-over event apart from the completion event.

// File: rtl/csio_pkg.sv
package csio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH
    } tx_state_e;

    localparam int WORD_W = 8;
    localparam int DIV_W  = 8;
endpackage

// File: rtl/csio_sync.sv
module csio_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain[g] <= d_in;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/csio_baud.sv
module csio_baud #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             src_en;
    logic             wrap;

    always_comb begin
        unique case (clk_sel)
            2'd0: src_en = 1'b1;
            2'd1: src_en = pre_cnt[0];
            2'd2: src_en = &pre_cnt[2:0];
            default: src_en = &pre_cnt[PRE_W-1:0];
        endcase
    end

    assign wrap = (div_cnt >= div_n);
    assign tick = run && src_en && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
            if (src_en) begin
                div_cnt <= wrap ? '0 : div_cnt + 1'b1;
            end
        end
    end

    assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $stable(div_n)) |-> (div_cnt <= div_n));
endmodule

// File: rtl/csio_tx_fsm.sv
module csio_tx_fsm
    import csio_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              cts_ok,
    input  logic              irq_sel,
    input  logic              irq_ack,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sclk,
    output logic              sdata,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq,
    output logic              run
);
    localparam int CNT_W = $clog2(WORD_W);

    tx_state_e         state, nxt;
    logic [WORD_W-1:0] buf_q, shreg;
    logic              buf_full;
    logic [CNT_W-1:0]  bit_cnt;
    logic              last_bit, start_ok, load, shift, done;

    assign last_bit = (bit_cnt == CNT_W'(WORD_W-1));
    assign start_ok = buf_full && tx_en && cts_ok;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start_ok) nxt = ST_LOW;                      // START
            ST_LOW:  if (tick) nxt = ST_HIGH;                         // RISE
            ST_HIGH: if (tick) begin
                if (!last_bit)     nxt = ST_LOW;                      // NEXT_BIT
                else if (start_ok) nxt = ST_LOW;                      // CHAIN
                else               nxt = ST_IDLE;                     // FINISH
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign load  = (state == ST_IDLE && start_ok) ||
                   (state == ST_HIGH && tick && last_bit && start_ok);
    assign shift = (state == ST_HIGH) && tick && !last_bit;
    assign done  = (state == ST_HIGH) && tick && last_bit && !start_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q    <= '0;
            buf_full <= 1'b0;
            shreg    <= '0;
            bit_cnt  <= '0;
            irq      <= 1'b0;
        end else begin
            if (wr_en) buf_q <= wr_data;
            if (wr_en)     buf_full <= 1'b1;
            else if (load) buf_full <= 1'b0;
            if (load) begin
                shreg   <= buf_q;
                bit_cnt <= '0;
            end else if (shift) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (irq_sel ? done : load) irq <= 1'b1;
            else if (irq_ack)          irq <= 1'b0;
        end
    end

    always_comb begin
        sclk        = (state != ST_LOW);
        sdata       = (state == ST_IDLE) ? 1'b1 : shreg[0];
        buf_empty   = !buf_full;
        shift_empty = (state == ST_IDLE);
        run         = (state != ST_IDLE);
    end

    assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk) && !shift_empty) |-> $stable(sdata));
    assert_load_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !sclk);
    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> (sclk && sdata));
    assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(cts_ok && tx_en));
    assert_no_idle_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_empty) |-> $past(!start_ok));
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && $past(!irq_sel) && $past(!wr_en)) |-> buf_empty);
endmodule

// File: rtl/csio_tx.sv
module csio_tx
    import csio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             cts_n,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] div_n,
    input  logic             irq_sel,
    input  logic             irq_ack,
    input  logic             wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic             sclk,
    output logic             sdata,
    output logic             buf_empty,
    output logic             shift_empty,
    output logic             irq
);
    logic cts_n_sync, tick, run;

    csio_sync #(.STAGES(2), .RST_VAL(1'b1)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (cts_n),
        .q_out (cts_n_sync)
    );

    csio_baud #(.DIV_W(DIV_W), .PRE_W(5)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clk_sel (clk_sel),
        .div_n   (div_n),
        .tick    (tick)
    );

    csio_tx_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .tx_en       (tx_en),
        .cts_ok      (!cts_n_sync),
        .irq_sel     (irq_sel),
        .irq_ack     (irq_ack),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .sclk        (sclk),
        .sdata       (sdata),
        .buf_empty   (buf_empty),
        .shift_empty (shift_empty),
        .irq         (irq),
        .run         (run)
    );
endmodule

// File: tb/test_csio_tx.sv
module test_csio_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       cts_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [7:0] div_n = 8'd0;
    logic       irq_sel = 1'b0;
    logic       irq_ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       sclk, sdata, buf_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;
    int exp_half = 1;
    int nfalls = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    csio_tx i_csio_tx (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .cts_n(cts_n),
        .clk_sel(clk_sel), .div_n(div_n), .irq_sel(irq_sel),
        .irq_ack(irq_ack), .wr_en(wr_en), .wr_data(wr_data),
        .sclk(sclk), .sdata(sdata), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: rebuilds words at rising edges and measures phase lengths
    logic       prev_sclk = 1'b1;
    logic       in_word = 1'b0;
    int         low_cnt = 0;
    int         high_cnt = 0;
    int         nbits = 0;
    logic [7:0] got = 8'd0;
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (!prev_sclk && sclk) begin
                check("R2 low phase", low_cnt, exp_half);
                got = {sdata, got[7:1]};
                nbits++;
                high_cnt = 0;
                if (nbits == 8) begin
                    nbits = 0;
                    if (exp_q.size() == 0) begin
                        check("R3 unexpected word", 1, 0);
                    end else begin
                        check("R3 word", int'(got), int'(exp_q.pop_front()));
                    end
                end
            end
            if (prev_sclk && !sclk) begin
                nfalls++;
                if (in_word) check("R8 high phase", high_cnt, exp_half);
                in_word = 1'b1;
                low_cnt = 0;
            end
            if (shift_empty) in_word = 1'b0;
            if (sclk) high_cnt++;
            else      low_cnt++;
            prev_sclk = sclk;
        end
    end

    task automatic cfg(input logic [1:0] sel, input int n);
        int mult;
        mult = (sel == 0) ? 1 : (sel == 1) ? 2 : (sel == 2) ? 8 : 32;
        @(negedge clk);
        clk_sel = sel;
        div_n = 8'(n);
        exp_half = (n + 1) * mult;
    endtask

    task automatic send(input logic [7:0] b);
        int guard = 0;
        while (!buf_empty && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(posedge clk);
        #1 check("R4 buf_empty after write", int'(buf_empty), 0);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (!(buf_empty && shift_empty) && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 sclk", int'(sclk), 1);
        check("R1 sdata", int'(sdata), 1);
        check("R1 buf_empty", int'(buf_empty), 1);
        check("R1 shift_empty", int'(shift_empty), 1);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        tx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R2/R3/R5 single word, divide by 1
        cfg(2'd0, 1);
        send(8'hA5);
        wait_idle();
        check("R5 shift_empty idle", int'(shift_empty), 1);
        check("R5 sclk idle", int'(sclk), 1);
        check("R3 queue drained", exp_q.size(), 0);

        // R2 other count sources
        cfg(2'd1, 3); send(8'h3C); wait_idle();
        cfg(2'd2, 2); send(8'h81); wait_idle();
        cfg(2'd3, 0); send(8'h5E); wait_idle();
        check("R2 queue drained", exp_q.size(), 0);

        // R8 back-to-back chaining
        cfg(2'd0, 2);
        send(8'h01); send(8'hFE); send(8'h96);
        wait_idle();
        check("R8 queue drained", exp_q.size(), 0);

        // R6 cts high blocks start
        @(negedge clk); cts_n = 1'b1;
        repeat (5) @(negedge clk);
        f0 = nfalls;
        send(8'h77);
        repeat (120) @(negedge clk);
        check("R6 no clock pulses", nfalls - f0, 0);
        check("R6 no start shift_empty", int'(shift_empty), 1);
        check("R6 word held buf_empty", int'(buf_empty), 0);
        @(negedge clk); cts_n = 1'b0;
        wait_idle();
        check("R6 sent after cts low", exp_q.size(), 0);

        // R6 cts rising mid-word: current completes, pending waits
        cfg(2'd0, 3);
        send(8'hC3);
        send(8'h2D);
        repeat (6) @(negedge clk);
        cts_n = 1'b1;
        repeat (200) @(negedge clk);
        check("R6 mid-word completed", exp_q.size(), 1);
        check("R6 pending held", int'(buf_empty), 0);
        check("R6 idle after word", int'(shift_empty), 1);
        @(negedge clk); cts_n = 1'b0;
        wait_idle();
        check("R6 pending sent", exp_q.size(), 0);

        // R7 tx_en low blocks start
        @(negedge clk); tx_en = 1'b0;
        f0 = nfalls;
        send(8'h44);
        repeat (100) @(negedge clk);
        check("R7 no clock pulses", nfalls - f0, 0);
        check("R7 no start", int'(shift_empty), 1);
        @(negedge clk); tx_en = 1'b1;
        wait_idle();
        check("R7 sent after enable", exp_q.size(), 0);

        // R9 irq on hand-over
        ack();
        check("R10 irq cleared by ack", int'(irq), 0);
        irq_sel = 1'b0;
        cfg(2'd0, 4);
        send(8'h12);
        repeat (3) @(negedge clk);
        check("R9 irq after load", int'(irq), 1);
        check("R9 word still shifting", int'(shift_empty), 0);
        ack();
        check("R10 ack clears", int'(irq), 0);
        wait_idle();
        check("R9 no irq at completion", int'(irq), 0);

        // R10 irq on completion
        @(negedge clk); irq_sel = 1'b1;
        send(8'hE7);
        repeat (3) @(negedge clk);
        check("R10 no irq at load", int'(irq), 0);
        wait_idle();
        @(negedge clk);
        check("R10 irq at completion", int'(irq), 1);
        ack();
        check("R10 ack clears again", int'(irq), 0);
        check("R3 final queue", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule